// File: doc/BRIEF.md
# System Data Command Transfer Scheduler

This block runs in the processor core clock domain. It turns each system data command into timed actions on the data bus. A fill command makes the block raise a sample strobe for each incoming data beat. The first strobe comes after a fixed offset plus a programmable delay. A write-data command makes the block raise an output-driver enable for each outgoing beat. The write waits for a frame edge of the system clock, signalled by a one-cycle pulse, that arrives late enough after the command has passed through a short receive pipeline of programmable length.

Only one command may wait for its timing window at a time. A command that arrives while another is waiting, or while the unit for its own direction is still busy, is dropped and sets a sticky error flag. A second sticky flag records bus contention, which is a fill that starts sampling while the drivers are still enabled.

Top module: `sysdc_sched`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block clears all pending state. In the following cycle `smp_strobe`, `smp_beat`, `drv_en`, `drv_beat`, `err_overlap` and `err_contention` are all zero.
- R2: A command is a cycle with `cmd_valid` high. `cmd_is_write` = 0 selects a fill. An accepted fill in cycle C with `sample_dly` = D (0 to 31) raises `smp_strobe` in cycles C+10+D through C+17+D, with `smp_beat` counting 0 to 7 over those cycles. `smp_strobe` is low in every other cycle.
- R3: The fill timing of R2 is the same for every value of `rcv_preset`.
- R4: `cmd_is_write` = 1 selects a write. An accepted write in cycle C with `rcv_preset` = P becomes eligible in cycle C+9+P. The transfer starts at the first cycle F at or after that point in which `frame_edge` is high, and `drv_en` rises in cycle F+1. A `frame_edge` pulse before C+9+P is ignored.
- R5: A write transfer holds `drv_en` high for exactly 8 consecutive cycles, with `drv_beat` counting 0 to 7. `drv_en` is low at all other times.
- R6: A command is pending from the cycle after it is accepted until its window opens: for a fill through C+9+D, for a write through C+8+P. A command is rejected if it arrives while any command is pending, or while the unit for its own direction is still busy (a fill up to its last strobe, a write up to its last driven beat). A rejected command produces no strobe or enable, and sets `err_overlap` from the next cycle.
- R7: If `smp_strobe` is high with `smp_beat` = 0 in a cycle where `drv_en` is also high, `err_contention` is set from the next cycle.
- R8: Once set, `err_overlap` and `err_contention` stay high until reset.
- R9: A write that has become eligible and is waiting for a frame edge does not block a fill command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_is_write | input | 1 | 1 = write-data command, 0 = fill command |
| sample_dly | input | 5 | Programmable fill sample delay in core cycles |
| rcv_preset | input | 2 | Receive-pipeline length in core cycles, applied to write commands |
| frame_edge | input | 1 | One-cycle pulse marking a system-clock frame edge |
| smp_strobe | output | 1 | Sample the incoming data beat in this cycle |
| smp_beat | output | 3 | Index of the incoming beat being sampled |
| drv_en | output | 1 | Enable the output data drivers |
| drv_beat | output | 3 | Index of the outgoing beat being driven |
| err_overlap | output | 1 | Sticky flag: a command was rejected |
| err_contention | output | 1 | Sticky flag: a fill started while the drivers were enabled |

## Verification
The bench builds the block with its default parameters: a 5-bit delay, a 2-bit preset, 8 beats, a fill offset of 10 and a write eligibility offset of 9. This covers the delay extremes 0 and 31 and all four preset values. A behavioural model tracks each accepted command by its cycle number and is compared with every output on every cycle. A free-running frame pulse with a selectable period places edges just before and just after the eligibility point. Hand-placed pulses hold a write in the armed state, so a fill can be made to start under an active driver.

// File: rtl/sysdc_pkg.sv
// Shared types for the system data command scheduler.
package sysdc_pkg;

    // Fill path phases: idle, counting down the sample delay, sampling beats.
    typedef enum logic [1:0] {
        F_IDLE,
        F_WAIT,
        F_XFER
    } fill_st_e;

    // Write path phases: idle, receive pipeline plus eligibility offset,
    // waiting for an eligible frame edge, driving beats.
    typedef enum logic [1:0] {
        W_IDLE,
        W_PIPE,
        W_ARMED,
        W_XFER
    } wr_st_e;

endpackage

// File: rtl/sysdc_fill_path.sv
// Fill sampling timer.
// Counts FILL_BASE + dly cycles from an accepted fill, then raises the sample
// strobe for BEATS consecutive cycles with a running beat index.
// Assumes: start is only asserted while busy is low (the top guards this).
module sysdc_fill_path #(
    parameter int DLY_W     = 5,
    parameter int FILL_BASE = 10,
    parameter int BEATS     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [DLY_W-1:0]           dly,
    output logic                       waiting,
    output logic                       busy,
    output logic                       strobe,
    output logic [$clog2(BEATS)-1:0]   beat
);
    import sysdc_pkg::*;

    localparam int BEAT_W = $clog2(BEATS);
    localparam int CNT_W  = $clog2(FILL_BASE + (1 << DLY_W)) + 1;

    fill_st_e           state;
    logic [CNT_W-1:0]   cnt;

    // Phase sequencing: load delay, count down, then step through the beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
            cnt   <= '0;
            beat  <= '0;
        end else begin
            case (state)
                F_IDLE: begin
                    if (start) begin
                        cnt   <= CNT_W'(FILL_BASE - 1) + CNT_W'(dly);
                        state <= F_WAIT;
                    end
                end
                F_WAIT: begin
                    if (cnt == CNT_W'(1)) begin
                        beat  <= '0;
                        state <= F_XFER;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                F_XFER: begin
                    if (beat == BEAT_W'(BEATS - 1)) begin
                        state <= F_IDLE;
                    end else begin
                        beat <= beat + BEAT_W'(1);
                    end
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    // Status decode for the top and the error tracker.
    always_comb begin
        waiting = (state == F_WAIT);
        busy    = (state != F_IDLE);
        strobe  = (state == F_XFER);
    end

    // R2: sampling always opens on beat zero.
    a_r2_first_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> (beat == '0));

    // R2: beats advance by one on consecutive cycles.
    a_r2_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && beat != BEAT_W'(BEATS - 1)) |=> (strobe && beat == $past(beat) + BEAT_W'(1)));

    // R2: the strobe drops right after the last beat.
    a_r2_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && beat == BEAT_W'(BEATS - 1)) |=> !strobe);

endmodule

// File: rtl/sysdc_write_path.sv
// Write driving timer.
// After an accepted write, waits WR_MIN-1+preset cycles (receive pipeline
// plus eligibility offset), then waits for the first frame edge pulse and
// enables the drivers for BEATS cycles starting the cycle after that edge.
// Assumes: start is only asserted while busy is low (the top guards this).
module sysdc_write_path #(
    parameter int PRE_W  = 2,
    parameter int WR_MIN = 9,
    parameter int BEATS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [PRE_W-1:0]           preset,
    input  logic                       frame_edge,
    output logic                       pipe,
    output logic                       busy,
    output logic                       drv_en,
    output logic [$clog2(BEATS)-1:0]   beat
);
    import sysdc_pkg::*;

    localparam int BEAT_W = $clog2(BEATS);
    localparam int CNT_W  = $clog2(WR_MIN + (1 << PRE_W)) + 1;

    wr_st_e             state;
    logic [CNT_W-1:0]   cnt;

    // Phase sequencing: pipeline countdown, frame edge wait, beat stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
            cnt   <= '0;
            beat  <= '0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (start) begin
                        cnt   <= CNT_W'(WR_MIN - 1) + CNT_W'(preset);
                        state <= W_PIPE;
                    end
                end
                W_PIPE: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= W_ARMED;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                W_ARMED: begin
                    if (frame_edge) begin
                        beat  <= '0;
                        state <= W_XFER;
                    end
                end
                W_XFER: begin
                    if (beat == BEAT_W'(BEATS - 1)) begin
                        state <= W_IDLE;
                    end else begin
                        beat <= beat + BEAT_W'(1);
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // Status decode for the top and the error tracker.
    always_comb begin
        pipe   = (state == W_PIPE);
        busy   = (state != W_IDLE);
        drv_en = (state == W_XFER);
    end

    // R4: drivers only switch on after a frame edge in the previous cycle.
    a_r4_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(frame_edge));

    // R4: an edge seen during the pipeline countdown does not start driving.
    a_r4_early_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && frame_edge) |=> !drv_en);

    // R5: beats advance by one on consecutive cycles.
    a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && beat != BEAT_W'(BEATS - 1)) |=> (drv_en && beat == $past(beat) + BEAT_W'(1)));

    // R5: drivers turn off right after the last beat.
    a_r5_drive_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && beat == BEAT_W'(BEATS - 1)) |=> !drv_en);

endmodule

// File: rtl/sysdc_err_track.sv
// Sticky protocol error flags.
// Records rejected commands and fills that start sampling while the output
// drivers are on; both flags hold until reset.
// Assumes: event inputs are single-cycle qualified conditions from the top.
module sysdc_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic overlap_evt,
    input  logic fill_first,
    input  logic drv_on,
    output logic err_overlap,
    output logic err_contention
);

    // Flag capture: set on event, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overlap    <= 1'b0;
            err_contention <= 1'b0;
        end else begin
            if (overlap_evt) begin
                err_overlap <= 1'b1;
            end
            if (fill_first && drv_on) begin
                err_contention <= 1'b1;
            end
        end
    end

    // R8: overlap flag is sticky.
    a_r8_overlap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |=> err_overlap);

    // R8: contention flag is sticky.
    a_r8_contention_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_contention |=> err_contention);

    // R7: contention only appears after a fill start under active drivers.
    a_r7_contention_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_contention) |-> $past(fill_first && drv_on));

endmodule

// File: rtl/sysdc_sched.sv
// System data command transfer scheduler (top).
// Accepts fill and write-data commands, allows one pending command at a
// time, and hands each to its timing path. Rejected commands and bus
// contention are flagged through the error tracker.
// Assumes: all inputs are synchronous to clk; frame_edge is a one-cycle pulse.
module sysdc_sched #(
    parameter int DLY_W     = 5,
    parameter int PRE_W     = 2,
    parameter int BEATS     = 8,
    parameter int FILL_BASE = 10,
    parameter int WR_MIN    = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic                       cmd_is_write,
    input  logic [DLY_W-1:0]           sample_dly,
    input  logic [PRE_W-1:0]           rcv_preset,
    input  logic                       frame_edge,
    output logic                       smp_strobe,
    output logic [$clog2(BEATS)-1:0]   smp_beat,
    output logic                       drv_en,
    output logic [$clog2(BEATS)-1:0]   drv_beat,
    output logic                       err_overlap,
    output logic                       err_contention
);

    localparam int BEAT_W = $clog2(BEATS);

    logic f_waiting, f_busy, w_pipe, w_busy;
    logic blocked, fill_go, write_go, overlap_evt, fill_first;

    // Acceptance: one pending command, and the target direction must be free.
    always_comb begin
        blocked     = f_waiting | w_pipe | (cmd_is_write ? w_busy : f_busy);
        fill_go     = cmd_valid & ~cmd_is_write & ~blocked;
        write_go    = cmd_valid &  cmd_is_write & ~blocked;
        overlap_evt = cmd_valid & blocked;
        fill_first  = smp_strobe & (smp_beat == BEAT_W'(0));
    end

    sysdc_fill_path #(
        .DLY_W     (DLY_W),
        .FILL_BASE (FILL_BASE),
        .BEATS     (BEATS)
    ) fill_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fill_go),
        .dly     (sample_dly),
        .waiting (f_waiting),
        .busy    (f_busy),
        .strobe  (smp_strobe),
        .beat    (smp_beat)
    );

    sysdc_write_path #(
        .PRE_W  (PRE_W),
        .WR_MIN (WR_MIN),
        .BEATS  (BEATS)
    ) write_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (write_go),
        .preset     (rcv_preset),
        .frame_edge (frame_edge),
        .pipe       (w_pipe),
        .busy       (w_busy),
        .drv_en     (drv_en),
        .beat       (drv_beat)
    );

    sysdc_err_track err_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .overlap_evt    (overlap_evt),
        .fill_first     (fill_first),
        .drv_on         (drv_en),
        .err_overlap    (err_overlap),
        .err_contention (err_contention)
    );

    // R6: never more than one command in its pending window.
    a_r6_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({f_waiting, w_pipe}));

    // R6: a command arriving while blocked raises the overlap flag.
    a_r6_overlap_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && blocked) |=> err_overlap);

    // R1: outputs are quiet in the cycle after a reset edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!smp_strobe && !drv_en && !err_overlap && !err_contention));

endmodule

// File: tb/sysdc_sched_tb_top.sv
`timescale 1ns/1ps
module sysdc_sched_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_write = 1'b0;
    logic [4:0] sample_dly = '0;
    logic [1:0] rcv_preset = '0;
    logic       fr_auto = 1'b0;
    logic       fr_man = 1'b0;
    logic       frame_edge;
    logic       smp_strobe, drv_en, err_overlap, err_contention;
    logic [2:0] smp_beat, drv_beat;

    assign frame_edge = fr_auto | fr_man;

    always #2.5 clk = ~clk;

    sysdc_sched dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_is_write   (cmd_is_write),
        .sample_dly     (sample_dly),
        .rcv_preset     (rcv_preset),
        .frame_edge     (frame_edge),
        .smp_strobe     (smp_strobe),
        .smp_beat       (smp_beat),
        .drv_en         (drv_en),
        .drv_beat       (drv_beat),
        .err_overlap    (err_overlap),
        .err_contention (err_contention)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit chk_en = 0;
    int fr_per = 0;
    int fr_ph = 0;

    // Reference model: each accepted command kept by its cycle number.
    bit f_act = 0;  int f_c0 = 0;  int f_d = 0;
    bit w_act = 0;  int w_c0 = 0;  int w_pre = 0;  int w_start = -1;
    bit e_ovl = 0;  bit e_cnt = 0;

    // Monitors for directed checks.
    int last_cmd = 0;
    int smp_rise = -1;
    int drv_rise = -1;
    int smp_count = 0;
    logic smp_prev = 1'b0, drv_prev = 1'b0;

    function automatic bit m_smp(int cc);
        return f_act && cc >= f_c0 + 10 + f_d && cc <= f_c0 + 17 + f_d;
    endfunction
    function automatic int m_sbeat(int cc);
        return cc - (f_c0 + 10 + f_d);
    endfunction
    function automatic bit m_drv(int cc);
        return w_act && w_start >= 0 && cc >= w_start && cc <= w_start + 7;
    endfunction
    function automatic int m_dbeat(int cc);
        return cc - w_start;
    endfunction

    // Model update on each rising edge, from the inputs of the cycle that ends.
    always @(posedge clk) begin
        int cq;
        bit f_wait_m, f_busy_m, w_pipe_m, w_busy_m, blk;
        cq = cyc;
        if (!rst_n) begin
            f_act = 0; w_act = 0; w_start = -1; e_ovl = 0; e_cnt = 0;
        end else begin
            if (m_smp(cq) && m_sbeat(cq) == 0 && m_drv(cq)) e_cnt = 1;
            if (w_act && w_start < 0 && cq >= w_c0 + 9 + w_pre && frame_edge)
                w_start = cq + 1;
            if (cmd_valid) begin
                f_wait_m = f_act && cq >= f_c0 + 1 && cq <= f_c0 + 9 + f_d;
                f_busy_m = f_act && cq >= f_c0 + 1 && cq <= f_c0 + 17 + f_d;
                w_pipe_m = w_act && cq >= w_c0 + 1 && cq <= w_c0 + 8 + w_pre;
                w_busy_m = w_act && cq >= w_c0 + 1 && (w_start < 0 || cq <= w_start + 7);
                blk = f_wait_m || w_pipe_m || (cmd_is_write ? w_busy_m : f_busy_m);
                if (blk) e_ovl = 1;
                else if (cmd_is_write) begin
                    w_act = 1; w_c0 = cq; w_pre = int'(rcv_preset); w_start = -1;
                end else begin
                    f_act = 1; f_c0 = cq; f_d = int'(sample_dly);
                end
            end
        end
        cyc = cyc + 1;
    end

    task automatic chk(string req, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d got %0d expected %0d", req, what, cyc, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R2", "smp_strobe", int'(smp_strobe), int'(m_smp(cyc)));
            if (m_smp(cyc)) chk("R2", "smp_beat", int'(smp_beat), m_sbeat(cyc));
            chk("R5", "drv_en", int'(drv_en), int'(m_drv(cyc)));
            if (m_drv(cyc)) chk("R5", "drv_beat", int'(drv_beat), m_dbeat(cyc));
            chk("R6", "err_overlap", int'(err_overlap), int'(e_ovl));
            chk("R7", "err_contention", int'(err_contention), int'(e_cnt));
        end
        if (smp_strobe && !smp_prev) smp_rise = cyc;
        if (drv_en && !drv_prev) drv_rise = cyc;
        if (smp_strobe) smp_count++;
        smp_prev = smp_strobe;
        drv_prev = drv_en;
        fr_auto <= (fr_per > 0) && ((cyc % (fr_per > 0 ? fr_per : 1)) == fr_ph);
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(bit wr, int d, int p);
        cmd_valid = 1'b1; cmd_is_write = wr;
        sample_dly = 5'(d); rcv_preset = 2'(p);
        last_cmd = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    // Fill directed check: first strobe exactly 10 + D after the command (R2, R3).
    task automatic fill_case(string req, int d, int p);
        int c0;
        smp_rise = -1;
        send(1'b0, d, p);
        c0 = last_cmd;
        tick(d + 22);
        chk(req, "fill first strobe offset", smp_rise - c0, 10 + d);
    endtask

    // Write directed check: drivers start after first eligible frame edge (R4).
    task automatic write_case(int p, int per, int ph);
        int c0, elig, edge_c;
        fr_per = per; fr_ph = ph;
        tick(2);
        drv_rise = -1;
        send(1'b1, 0, p);
        c0 = last_cmd;
        elig = c0 + 9 + p;
        edge_c = elig;
        while ((edge_c % per) != ph) edge_c++;
        tick(9 + p + per + 12);
        chk("R4", "write drive start", drv_rise, edge_c + 1);
        fr_per = 0;
        tick(4);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog cycle %0d got running expected finished", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        tick(1);
        do_reset();
        // R1: quiet outputs right after reset.
        chk("R1", "smp_strobe after reset", int'(smp_strobe), 0);
        chk("R1", "drv_en after reset", int'(drv_en), 0);
        chk("R1", "err_overlap after reset", int'(err_overlap), 0);
        chk("R1", "err_contention after reset", int'(err_contention), 0);
        chk_en = 1;

        // R2: fill timing across the delay range.
        fill_case("R2", 0, 0);
        fill_case("R2", 31, 0);
        fill_case("R2", 7, 0);
        // R3: same delay with different presets gives the same offset.
        fill_case("R3", 4, 0);
        fill_case("R3", 4, 3);
        fill_case("R3", 0, 2);

        // R4 and R5: writes for every preset, frame phases close to eligibility.
        write_case(0, 4, 1);
        write_case(1, 5, 3);
        write_case(2, 6, 0);
        write_case(3, 3, 2);
        write_case(0, 7, 5);
        chk("R5", "drv_en idle after writes", int'(drv_en), 0);

        // R6: second fill during a pending fill is dropped.
        base = smp_count;
        send(1'b0, 3, 0);
        tick(2);
        send(1'b0, 0, 0);
        tick(1);
        chk("R6", "err_overlap after blocked fill", int'(err_overlap), 1);
        tick(40);
        chk("R6", "strobes from one fill only", smp_count - base, 8);

        // R6: fill during a write pipeline is dropped as well.
        fr_per = 4; fr_ph = 0;
        base = smp_count;
        send(1'b1, 0, 2);
        tick(3);
        send(1'b0, 1, 0);
        tick(40);
        chk("R6", "no strobes for fill during write pipeline", smp_count - base, 0);
        fr_per = 0;
        tick(4);

        // R9 and R7: armed write does not block a fill; late edge causes contention.
        base = smp_count;
        send(1'b1, 0, 0);
        tick(9);
        send(1'b0, 0, 0);
        tick(3);
        fr_man = 1'b1;
        @(negedge clk);
        fr_man = 1'b0;
        tick(20);
        chk("R9", "fill accepted while write armed", smp_count - base, 8);
        chk("R7", "err_contention set", int'(err_contention), 1);

        // R8: flags hold through further traffic.
        fill_case("R2", 2, 1);
        chk("R8", "err_overlap held", int'(err_overlap), 1);
        chk("R8", "err_contention held", int'(err_contention), 1);

        // R1: reset in the middle of a fill clears everything.
        send(1'b0, 5, 0);
        tick(3);
        do_reset();
        chk("R1", "err_overlap cleared", int'(err_overlap), 0);
        chk("R1", "err_contention cleared", int'(err_contention), 0);
        base = smp_count;
        tick(30);
        chk("R1", "no strobes after reset", smp_count - base, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule